// File: doc/BRIEF.md
# Asynchronously Clocked Timer Bridge

An 8-bit counter runs on its own slow timer clock, unrelated to the processor I/O clock. A register bridge joins the two domains. The processor sees the count through a holding register. It writes the compare value and the control bits through synchronizing bridges, and each bridge raises an update-busy bit until its value has landed in the timer domain. Compare-match and overflow events travel back to the processor domain as sticky flags. Each flag is gated by its own enable bit and by a global enable to form an interrupt request. A compare output pin is toggled directly in the timer domain.

A sleep request stops the processor side. Here a stopped I/O clock is represented by freezing the count holding register. A timer interrupt condition raises a wake pulse in the timer domain. Once that pulse has been synchronized, the processor side resumes and holds the processor for a fixed number of I/O cycles. Right after wake-up, reads of the count still return the value from before sleep. The holding register only changes again when a fresh timer-clock edge has been carried across.

Top module: `async_timer_bridge`

## Requirements
- R1: While control bit 0 (run) is one, the counter advances by one on every rising timer-clock edge and wraps from 255 to 0; while it is zero the counter holds.
- R2: `cnt_o` is refreshed with the post-edge count on every timer-clock edge, three I/O clock edges after that timer edge. It holds its value while the processor side is asleep and during the halt window after wake-up.
- R3: A write to address 0 (compare) or address 1 (control) sets `busy_o[0]` or `busy_o[1]`, visible the cycle after the write. The bit stays set for at least two timer-clock edges and clears once the value has been transferred and acknowledged.
- R4: A write to the compare or control register while its busy bit is set is dropped.
- R5: When the counter advances from a value equal to the compare value, the compare flag sets three I/O cycles after that timer edge. In that same cycle `cnt_o` reads compare+1.
- R6: When the counter wraps from 255 to 0, the overflow flag sets with the same latency, and `cnt_o` reads 0 in that cycle.
- R7: A write to address 2 clears the compare flag where data bit 0 is one and the overflow flag where data bit 1 is one. A flag event in the same cycle wins over the clear.
- R8: `irq_o[0]` is the compare flag ANDed with enable bit 0 and `gie_i`. `irq_o[1]` is the overflow flag ANDed with enable bit 1 and `gie_i`. The enable bits are written at address 3, data bits 1:0.
- R9: When control bit 1 is one, `oc_o` toggles on the timer edge of a compare match and at no other time.
- R10: `wake_o` rises on the timer edge that ends a cycle in which the counter matched and the matching enable bit was set. It lasts one timer-clock cycle and rises before the corresponding flag shows.
- R11: A pulse on `sleep_i` drops `io_clk_en_o`. A synchronized wake pulse raises `io_clk_en_o` again and asserts `halt_o` for exactly four I/O cycles.
- R12: After reset, the count, flags, enables, busy bits, interrupt requests, `oc_o`, `wake_o` and `halt_o` are zero, and `io_clk_en_o` is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor I/O clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| tclk_i | input | 1 | Asynchronous timer clock |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 compare, 1 control, 2 flag clear, 3 interrupt enables |
| wr_data_i | input | 8 | Write data |
| gie_i | input | 1 | Global interrupt enable |
| sleep_i | input | 1 | Sleep request pulse |
| cnt_o | output | 8 | Count holding register |
| busy_o | output | 2 | Update busy: bit 0 compare, bit 1 control |
| cmp_flag_o | output | 1 | Compare-match flag |
| ovf_flag_o | output | 1 | Overflow flag |
| irq_o | output | 2 | Interrupt requests: bit 0 compare, bit 1 overflow |
| oc_o | output | 1 | Compare output pin, timer domain |
| wake_o | output | 1 | Wake request, timer domain |
| halt_o | output | 1 | Processor halt after wake-up |
| io_clk_en_o | output | 1 | I/O clock running indicator |

## Verification
The assertions check the following on every cycle:
- the counter steps exactly by one under the run bit;
- a wake pulse only appears on a counting edge;
- the compare pin only moves on a qualified match;
- a busy bit only rises after a write, and a bridge's holding value stays frozen while busy;
- the count holding register stays still while asleep or halted;
- the halt window only starts out of sleep.

Some behaviours can only be shown by the bench scenarios, because they depend on the ratio between the two clocks:
- the exact flag latency and the count seen with it;
- the dropping of a write made while busy;
- the stale read across wake-up and the value that replaces it;
- the gating of each interrupt request.

// File: rtl/atb_pkg.sv
package atb_pkg;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned CTL_W = 2;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    A_CMP  = 2'd0,
    A_CTL  = 2'd1,
    A_FCLR = 2'd2,
    A_IEN  = 2'd3
  } addr_e;
  // snapshot word carried from timer to I/O domain
  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic             cmp_ev;
    logic             ovf_ev;
  } snap_t;
  localparam int unsigned SNAP_W = $bits(snap_t);
endpackage

// File: rtl/atb_wr_bridge.sv
// I/O -> timer register transfer, toggle request / acknowledge
module atb_wr_bridge #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic         busy_o,
  input  logic         tclk_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q, q_q;
  logic req_q, ack_q;
  logic [1:0] ack_s, req_s;

  assign busy_o = req_q ^ ack_s[1];
  assign q_o    = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      req_q  <= 1'b0;
      ack_s  <= '0;
    end else begin
      ack_s <= {ack_s[0], ack_q};
      if (wr_i && !busy_o) begin
        hold_q <= data_i;
        req_q  <= ~req_q;
      end
    end
  end

  // hold_q is stable while the request is outstanding
  always_ff @(posedge tclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_s <= '0;
      ack_q <= 1'b0;
      q_q   <= '0;
    end else begin
      req_s <= {req_s[0], req_q};
      if (req_s[1] != ack_q) begin
        q_q   <= hold_q;
        ack_q <= req_s[1];
      end
    end
  end

  p_hold_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(hold_q));
  p_busy_from_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_i));
endmodule

// File: rtl/atb_snap_sync.sv
// timer -> I/O snapshot: data registered with a toggle, toggle synchronized
module atb_snap_sync #(
  parameter int unsigned W = 10
) (
  input  logic         tclk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic         clk_i,
  output logic         pulse_o,
  output logic [W-1:0] data_o
);
  logic         tog_q;
  logic [W-1:0] data_q;
  logic [2:0]   tog_s;

  always_ff @(posedge tclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q  <= 1'b0;
      data_q <= '0;
    end else begin
      tog_q  <= ~tog_q;
      data_q <= d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_s <= '0;
    else         tog_s <= {tog_s[1:0], tog_q};
  end

  assign pulse_o = tog_s[1] ^ tog_s[2];
  assign data_o  = data_q;  // stable for a full timer period around pulse_o
endmodule

// File: rtl/atb_timer_core.sv
module atb_timer_core
  import atb_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         tclk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cmp_i,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic [1:0]   ien_i,
  output logic [W-1:0] cnt_next_o,
  output logic         cmp_ev_o,
  output logic         ovf_ev_o,
  output logic         oc_o,
  output logic         wake_o
);
  localparam logic [W-1:0] CNT_MAX = '1;
  logic [W-1:0] cnt_q, cnt_d;
  logic oc_q, wake_q, run, oc_en, cmp_hit, ovf_hit;
  logic [1:0] ien_s1, ien_s2;

  assign run     = ctl_i[0];
  assign oc_en   = ctl_i[1];
  assign cmp_hit = run && (cnt_q == cmp_i);
  assign ovf_hit = run && (cnt_q == CNT_MAX);
  assign cnt_d   = run ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge tclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      oc_q   <= 1'b0;
      wake_q <= 1'b0;
      ien_s1 <= '0;
      ien_s2 <= '0;
    end else begin
      ien_s1 <= ien_i;
      ien_s2 <= ien_s1;
      cnt_q  <= cnt_d;
      oc_q   <= oc_q ^ (cmp_hit & oc_en);
      wake_q <= (cmp_hit & ien_s2[0]) | (ovf_hit & ien_s2[1]);
    end
  end

  assign cnt_next_o = cnt_d;
  assign cmp_ev_o   = cmp_hit;
  assign ovf_ev_o   = ovf_hit;
  assign oc_o       = oc_q;
  assign wake_o     = wake_q;

  p_count_step_r1: assert property (@(posedge tclk_i) disable iff (!rst_ni)
    run |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_count_hold_r1: assert property (@(posedge tclk_i) disable iff (!rst_ni)
    !run |=> $stable(cnt_q));
  p_oc_on_match_r9: assert property (@(posedge tclk_i) disable iff (!rst_ni)
    (oc_q != $past(oc_q)) |-> $past(cmp_hit && oc_en));
  p_wake_on_step_r10: assert property (@(posedge tclk_i) disable iff (!rst_ni)
    wake_q |-> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/async_timer_bridge.sv
module async_timer_bridge
  import atb_pkg::*;
#(
  parameter int unsigned HALT_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tclk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              gie_i,
  input  logic              sleep_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [1:0]        busy_o,
  output logic              cmp_flag_o,
  output logic              ovf_flag_o,
  output logic [1:0]        irq_o,
  output logic              oc_o,
  output logic              wake_o,
  output logic              halt_o,
  output logic              io_clk_en_o
);
  localparam int unsigned HW = $clog2(HALT_CYCLES + 1);

  logic [CNT_W-1:0] cmp_t, cnt_next, cnt_q;
  logic [CTL_W-1:0] ctl_t;
  logic cmp_ev, ovf_ev, snap_pulse;
  snap_t snap_in, snap_out;
  logic [1:0] ien_q, flag_q;
  logic asleep_q, wake_rise;
  logic [2:0] wk_s;
  logic [HW-1:0] halt_q;

  atb_wr_bridge #(.W(CNT_W)) u_cmp_br (
    .clk_i, .rst_ni,
    .wr_i(wr_en_i && wr_addr_i == A_CMP), .data_i(wr_data_i),
    .busy_o(busy_o[0]), .tclk_i, .q_o(cmp_t));

  atb_wr_bridge #(.W(CTL_W)) u_ctl_br (
    .clk_i, .rst_ni,
    .wr_i(wr_en_i && wr_addr_i == A_CTL), .data_i(wr_data_i[CTL_W-1:0]),
    .busy_o(busy_o[1]), .tclk_i, .q_o(ctl_t));

  atb_timer_core u_core (
    .tclk_i, .rst_ni, .cmp_i(cmp_t), .ctl_i(ctl_t), .ien_i(ien_q),
    .cnt_next_o(cnt_next), .cmp_ev_o(cmp_ev), .ovf_ev_o(ovf_ev),
    .oc_o, .wake_o);

  assign snap_in = '{cnt: cnt_next, cmp_ev: cmp_ev, ovf_ev: ovf_ev};

  atb_snap_sync #(.W(SNAP_W)) u_snap (
    .tclk_i, .rst_ni, .d_i(snap_in), .clk_i,
    .pulse_o(snap_pulse), .data_o(snap_out));

  assign wake_rise = wk_s[1] & ~wk_s[2];
  assign halt_o    = (halt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      flag_q   <= '0;
      ien_q    <= '0;
      asleep_q <= 1'b0;
      wk_s     <= '0;
      halt_q   <= '0;
    end else begin
      wk_s <= {wk_s[1:0], wake_o};
      if (snap_pulse && !asleep_q && !halt_o) cnt_q <= snap_out.cnt;
      for (int i = 0; i < 2; i++) begin
        if (wr_en_i && wr_addr_i == A_FCLR && wr_data_i[i]) flag_q[i] <= 1'b0;
      end
      // set wins over clear
      if (snap_pulse && snap_out.cmp_ev) flag_q[0] <= 1'b1;
      if (snap_pulse && snap_out.ovf_ev) flag_q[1] <= 1'b1;
      if (wr_en_i && wr_addr_i == A_IEN) ien_q <= wr_data_i[1:0];
      if (asleep_q && wake_rise) begin
        asleep_q <= 1'b0;
        halt_q   <= HW'(HALT_CYCLES);
      end else begin
        if (sleep_i && !asleep_q) asleep_q <= 1'b1;
        if (halt_o) halt_q <= halt_q - 1'b1;
      end
    end
  end

  assign cnt_o       = cnt_q;
  assign cmp_flag_o  = flag_q[0];
  assign ovf_flag_o  = flag_q[1];
  assign irq_o       = flag_q & ien_q & {2{gie_i}};
  assign io_clk_en_o = ~asleep_q;

  p_stale_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep_q || halt_o) |=> $stable(cnt_q));
  p_halt_from_sleep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> $past(asleep_q));
  p_halt_not_asleep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !asleep_q);
endmodule

// File: tb/async_timer_bridge_test.sv
`timescale 1ns/1ps
module async_timer_bridge_test;
  logic clk = 1'b0, tclk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, gie = 1'b0, sleep = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] cnt;
  logic [1:0] busy, irq;
  logic cmp_flag, ovf_flag, oc, wake, halt, clk_en;
  int total = 0, bad = 0;

  always #10 clk = ~clk;    // 50 MHz
  always #71 tclk = ~tclk;  // ratio 7.1

  async_timer_bridge uut (
    .clk_i(clk), .rst_ni(rst_n), .tclk_i(tclk), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .gie_i(gie), .sleep_i(sleep),
    .cnt_o(cnt), .busy_o(busy), .cmp_flag_o(cmp_flag), .ovf_flag_o(ovf_flag),
    .irq_o(irq), .oc_o(oc), .wake_o(wake), .halt_o(halt), .io_clk_en_o(clk_en));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_cnt(logic [7:0] v);
    for (int i = 0; i < 4000 && cnt != v; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R12 cnt", cnt, 0); chk("R12 busy", busy, 0);
    chk("R12 flags", {cmp_flag, ovf_flag}, 0); chk("R12 irq", irq, 0);
    chk("R12 oc", oc, 0); chk("R12 wake/halt", {wake, halt}, 0);
    chk("R12 clk_en", clk_en, 1);
    repeat (30) @(negedge clk);
    chk("R1 no run holds count", cnt, 0);
  endtask

  task automatic t_busy;
    wr(2'd0, 8'd20);
    chk("R3 busy cmp set", busy[0], 1);
    wr(2'd0, 8'd99);  // dropped, R4
    repeat (3) @(negedge clk);
    chk("R3 busy held", busy[0], 1);
    for (int i = 0; i < 100 && busy[0]; i++) @(negedge clk);
    chk("R3 busy cmp clears", busy[0], 0);
    wr(2'd1, 8'd3);
    chk("R3 busy ctl set", busy[1], 1);
    for (int i = 0; i < 100 && busy[1]; i++) @(negedge clk);
    chk("R3 busy ctl clears", busy[1], 0);
  endtask

  task automatic t_compare;
    int n = 0;
    wr(2'd2, 8'd3);
    wait_cnt(8'd20);
    chk("R1 count reaches 20", cnt, 20);
    chk("R9 oc before match", oc, 0);
    for (int i = 0; i < 40 && !cmp_flag; i++) begin @(negedge clk); n++; end
    chk("R5 latency ok", int'(n >= 7 && n <= 8), 1);
    chk("R5 cnt with flag", cnt, 21);
    chk("R4 dropped write (match at 20)", cmp_flag, 1);
    chk("R9 oc toggled", oc, 1);
    chk("R8 irq gated by ien", irq, 0);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 4000 && !ovf_flag; i++) @(negedge clk);
    chk("R6 ovf flag", ovf_flag, 1);
    chk("R6 cnt on ovf", cnt, 0);
    chk("R2 count follows", cnt, 0);
  endtask

  task automatic t_irq_clear;
    wr(2'd3, 8'd1);
    chk("R8 gie off", irq, 0);
    gie = 1'b1; @(negedge clk);
    chk("R8 cmp irq", irq, 1);
    wr(2'd3, 8'd3);
    chk("R8 both irq", irq, 3);
    wr(2'd2, 8'd1);
    chk("R7 cmp cleared", cmp_flag, 0);
    chk("R7 ovf kept", ovf_flag, 1);
    wr(2'd2, 8'd2);
    chk("R7 ovf cleared", ovf_flag, 0);
    chk("R8 irq gone", irq, 0);
    wr(2'd3, 8'd1);
  endtask

  task automatic t_sleep;
    logic [7:0] v;
    int h = 0, n = 0;
    wait_cnt(8'd100);
    wr(2'd2, 8'd3);
    @(negedge clk); sleep = 1'b1; @(negedge clk); sleep = 1'b0;
    chk("R11 clk_en drops", clk_en, 0);
    v = cnt;
    repeat (50) @(negedge clk);
    chk("R2 held asleep", cnt, v);
    for (int i = 0; i < 4000 && !wake; i++) @(negedge clk);
    chk("R10 wake seen", wake, 1);
    chk("R10 wake before flag", cmp_flag, 0);
    for (int i = 0; i < 6 && !halt; i++) begin @(negedge clk); n++; end
    chk("R10 flag after wake", cmp_flag, 1);
    chk("R11 halt soon", int'(n <= 3), 1);
    chk("R11 clk_en back", clk_en, 1);
    while (halt && h < 10) begin
      chk("R2 stale during halt", cnt, v);
      @(negedge clk); h++;
    end
    chk("R11 halt length", h, 4);
    for (int i = 0; i < 20 && cnt == v; i++) @(negedge clk);
    chk("R2 fresh after wake", cnt, 22);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_busy;
    t_compare;
    t_overflow;
    t_irq_clear;
    t_sleep;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule